// File: doc/BRIEF.md
# Fault-Injecting Memory Slave

This block is a slave on an AHB-style bus that acts as a small byte-addressable memory. It exists to test bus masters: it can stall any data phase for a programmable number of cycles and can answer with ERROR or RETRY instead of OKAY.

Every accepted data phase gets a sequence number. The number starts at zero after reset or after a clear strobe and wraps at the table size. A side configuration port writes one table entry at a time. Each entry holds three values: a stall length, a response code, and a usage limit. The data phase whose number selects an entry uses that entry's settings.

A forced response stops after its usage limit is reached, and the entry then answers OKAY again. A limit of zero means the response never runs out. Memory contents survive every fault. Only transfers that complete with OKAY write to the memory or return read data.

Top module: `ahb_fault_mem`

## Requirements
- R1: While reset is held and directly after it, `bus_ready` is 1 and `bus_resp` is 00. After reset, every table entry gives zero stall cycles and an OKAY response with no limit.
- R2: A data phase whose entry has stall length N keeps `bus_ready` at 0 for exactly N cycles before it ends. During those cycles `bus_resp` is 00.
- R3: A forced response uses the codes 01 (ERROR) and 10 (RETRY). It comes after the stall cycles and lasts two cycles. In the first cycle `bus_ready` is 0, and in the second it is 1. `bus_resp` shows the code in both cycles.
- R4: With a nonzero limit L, an entry's forced code is given on the first L data phases that use that entry. Later uses answer OKAY. Writing the entry again restarts the count.
- R5: With a limit of 0, the forced code is given on every use of the entry.
- R6: Response code 11 is never driven. A configured code of 11 is stored as OKAY.
- R7: Data-phase numbers count accepted transfers from 0 and wrap modulo 16. A clear strobe sets the count to 0. If the clear comes in the same cycle as an accepted address phase, that phase uses entry 0 and the next one uses entry 1.
- R8: A write that completes with OKAY updates only the addressed byte lanes. Size 0 writes one byte, at lane addr[1:0]. Size 1 writes two bytes, at lanes 0-1 or 2-3 chosen by addr[1]. Size 2 writes all four lanes. Lane k holds the byte at word address + k and comes from `bus_wdata[8k+7:8k]`. A read that completes with OKAY returns the whole word.
- R9: A write that ends with ERROR or RETRY leaves the memory unchanged.
- R10: A transfer is accepted only when `bus_sel` is 1, `bus_trans` is 10 or 11, and `bus_ready_in` is 1. Any other cycle does not advance the data-phase count. With no data phase pending, the outputs are ready 1 and response 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Slave select |
| bus_trans | input | 2 | Transfer type (1x = valid transfer) |
| bus_addr | input | ADDR_W | Byte address |
| bus_write | input | 1 | 1 = write |
| bus_size | input | 3 | 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data (data phase) |
| bus_ready_in | input | 1 | Bus-wide ready seen by the slave |
| bus_ready | output | 1 | Slave ready |
| bus_resp | output | 2 | Response: 00 OKAY, 01 ERROR, 10 RETRY |
| bus_rdata | output | 32 | Read data |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | IDX_W | Entry selected |
| cfg_wait | input | WAIT_W | Stall length |
| cfg_resp | input | 2 | Forced response code |
| cfg_limit | input | LIM_W | Usage limit, 0 = unlimited |
| seq_clear | input | 1 | Restart data-phase numbering |

## Verification
The risky overlap is a clear strobe in the same cycle as an accepted address phase. In that cycle the clear competes with the normal increment of the phase number.

The bench provokes this case in two steps. First it advances the count by several transfers. Then it drives the clear together with a new address phase, with entry 0 set to ERROR and entry 1 set to two stall cycles. The check passes only if that transfer answers ERROR and the following one stalls exactly two cycles. The scoreboard compares both transfers against a table model kept inside the bench.

// File: rtl/ahb_fault_mem.sv
module ahb_fault_mem #(
  parameter int ADDR_W = 8,
  parameter int WAIT_W = 4,
  parameter int LIM_W  = 4,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic [1:0]        bus_trans,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_write,
  input  logic [2:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_ready_in,
  output logic              bus_ready,
  output logic [1:0]        bus_resp,
  output logic [31:0]       bus_rdata,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic [1:0]        cfg_resp,
  input  logic [LIM_W-1:0]  cfg_limit,
  input  logic              seq_clear
);
  localparam int WORDS   = 2 ** (ADDR_W - 2);
  localparam int ENTRIES = 2 ** IDX_W;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_FLT1, S_FLT2, S_DONE} st_t;

  logic [WAIT_W-1:0] tw [ENTRIES];
  logic [1:0]        tr [ENTRIES];
  logic [LIM_W-1:0]  tl [ENTRIES];
  logic [LIM_W-1:0]  tu [ENTRIES];
  logic [31:0]       mem [WORDS];

  logic [IDX_W-1:0]  seq_idx;
  st_t               st;
  logic [WAIT_W-1:0] wcnt;
  logic [1:0]        cur_resp;
  logic [ADDR_W-1:0] d_addr;
  logic              d_write;
  logic [2:0]        d_size;
  logic [3:0]        lane_en;

  wire accept = bus_sel && (bus_trans == 2'b10 || bus_trans == 2'b11) && bus_ready_in;
  wire [IDX_W-1:0] use_idx = seq_clear ? '0 : seq_idx;
  wire [1:0] prog = tr[use_idx];
  wire limited = (tl[use_idx] != '0);
  wire forced = (prog != 2'b00) && (!limited || tu[use_idx] < tl[use_idx]);
  wire [1:0] eff = forced ? prog : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tw[i] <= '0;
        tr[i] <= 2'b00;
        tl[i] <= '0;
        tu[i] <= '0;
      end
    end else begin
      if (accept && forced && limited) tu[use_idx] <= tu[use_idx] + 1'b1;
      if (cfg_we) begin
        tw[cfg_idx] <= cfg_wait;
        tr[cfg_idx] <= (cfg_resp == 2'b11) ? 2'b00 : cfg_resp;
        tl[cfg_idx] <= cfg_limit;
        tu[cfg_idx] <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seq_idx <= '0;
    else if (accept) seq_idx <= use_idx + 1'b1;
    else if (seq_clear) seq_idx <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      wcnt     <= '0;
      cur_resp <= 2'b00;
      d_addr   <= '0;
      d_write  <= 1'b0;
      d_size   <= 3'd0;
    end else begin
      case (st)
        S_WAIT: begin
          wcnt <= wcnt - 1'b1;
          if (wcnt == 1) st <= (cur_resp != 2'b00) ? S_FLT1 : S_DONE;
        end
        S_FLT1:  st <= S_FLT2;
        default: st <= S_IDLE;
      endcase
      if (accept) begin
        d_addr   <= bus_addr;
        d_write  <= bus_write;
        d_size   <= bus_size;
        cur_resp <= eff;
        wcnt     <= tw[use_idx];
        if (tw[use_idx] != '0)  st <= S_WAIT;
        else if (eff != 2'b00)  st <= S_FLT1;
        else                    st <= S_DONE;
      end
    end
  end

  always_comb begin
    case (d_size)
      3'd0:    lane_en = 4'b0001 << d_addr[1:0];
      3'd1:    lane_en = d_addr[1] ? 4'b1100 : 4'b0011;
      default: lane_en = 4'b1111;
    endcase
  end

  always_ff @(posedge clk) begin
    if (st == S_DONE && d_write)
      for (int k = 0; k < 4; k++)
        if (lane_en[k]) mem[d_addr[ADDR_W-1:2]][8*k +: 8] <= bus_wdata[8*k +: 8];
  end

  assign bus_ready = !(st == S_WAIT || st == S_FLT1);
  assign bus_resp  = (st == S_FLT1 || st == S_FLT2) ? cur_resp : 2'b00;
  assign bus_rdata = (st == S_DONE && !d_write) ? mem[d_addr[ADDR_W-1:2]] : 32'h0;
endmodule

module ahb_fault_mem_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_ready,
  input logic [1:0]       bus_resp,
  input logic             accept,
  input logic             seq_clear,
  input logic [IDX_W-1:0] seq_idx
);
  assert_never_code3_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_resp != 2'b11);

  assert_fault_second_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ready && bus_resp != 2'b00) |=> (bus_ready && bus_resp == $past(bus_resp)));

  assert_fault_preceded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && bus_resp != 2'b00) |-> ($past(!bus_ready) && $past(bus_resp) == bus_resp));

  assert_idx_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !seq_clear) |=> seq_idx == IDX_W'($past(seq_idx) + 1'b1));

  assert_clear_with_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && seq_clear) |=> seq_idx == IDX_W'(1));

  assert_no_count_without_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !seq_clear) |=> $stable(seq_idx));
endmodule

bind ahb_fault_mem ahb_fault_mem_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_ready(bus_ready), .bus_resp(bus_resp),
  .accept(accept), .seq_clear(seq_clear), .seq_idx(seq_idx)
);

// File: tb/ahb_fault_mem_bench.sv
module ahb_fault_mem_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        bus_sel, bus_write, bus_ready, cfg_we, seq_clear;
  logic [1:0]  bus_trans, bus_resp, cfg_resp;
  logic [7:0]  bus_addr;
  logic [2:0]  bus_size;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0]  cfg_idx, cfg_wait, cfg_limit;

  ahb_fault_mem u_ahb_fault_mem (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_trans(bus_trans),
    .bus_addr(bus_addr), .bus_write(bus_write), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_ready_in(bus_ready), .bus_ready(bus_ready),
    .bus_resp(bus_resp), .bus_rdata(bus_rdata), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_wait(cfg_wait), .cfg_resp(cfg_resp),
    .cfg_limit(cfg_limit), .seq_clear(seq_clear)
  );

  typedef struct {
    int          lows;
    logic [1:0]  resp;
    logic [31:0] rdata;
    bit          chk_rd;
    string       req;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  int m_wait[16], m_resp[16], m_lim[16], m_used[16];
  int m_idx = 0;
  logic [7:0] mdl [256];
  bit finished = 0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mword(int a);
    int b = a & ~3;
    return {mdl[b+3], mdl[b+2], mdl[b+1], mdl[b]};
  endfunction

  task automatic cfg(int i, int w, int r, int l);
    cfg_we = 1; cfg_idx = 4'(i); cfg_wait = 4'(w); cfg_resp = 2'(r); cfg_limit = 4'(l);
    @(posedge clk); #1;
    cfg_we = 0;
    m_wait[i] = w; m_resp[i] = (r == 3) ? 0 : r; m_lim[i] = l; m_used[i] = 0;
  endtask

  task automatic clear_seq();
    seq_clear = 1;
    @(posedge clk); #1;
    seq_clear = 0;
    m_idx = 0;
  endtask

  task automatic xfer(int addr, int size, bit wr, logic [31:0] wdata, bit clr, string req);
    exp_t e;
    int i = clr ? 0 : m_idx;
    int eff = 0;
    bit r;
    if (m_resp[i] != 0 && (m_lim[i] == 0 || m_used[i] < m_lim[i])) eff = m_resp[i];
    if (eff != 0 && m_lim[i] != 0) m_used[i]++;
    m_idx = (i + 1) % 16;
    e.lows = m_wait[i] + ((eff != 0) ? 1 : 0);
    e.resp = 2'(eff);
    e.rdata = mword(addr);
    e.chk_rd = !wr && eff == 0;
    e.req = req;
    if (wr && eff == 0) begin
      for (int k = 0; k < 4; k++) begin
        int b = (addr & ~3) + k;
        bit en = (size == 2) || (size == 1 && (k >> 1) == ((addr >> 1) & 1)) ||
                 (size == 0 && k == (addr & 3));
        if (en) mdl[b] = wdata[8*k +: 8];
      end
    end
    q.push_back(e);
    bus_sel = 1; bus_trans = 2'b10; bus_addr = 8'(addr); bus_size = 3'(size);
    bus_write = wr; seq_clear = clr;
    @(posedge clk); #1;
    bus_trans = 2'b00; bus_sel = 0; seq_clear = 0; bus_wdata = wdata;
    while (1) begin
      r = bus_ready;
      @(posedge clk); #1;
      if (r) break;
    end
  endtask

  bit   in_dp = 0;
  int   lows = 0;
  exp_t me;
  always @(negedge clk) begin
    if (rst_n) begin
      if (in_dp) begin
        if (!bus_ready) lows++;
        else begin
          in_dp = 0;
          if (q.size() == 0) check(0, "R10", "unexpected data phase", 0, 0);
          else begin
            me = q.pop_front();
            check(lows == me.lows, me.req, "stall cycles", 32'(lows), 32'(me.lows));
            check(bus_resp == me.resp, me.req, "response", 32'(bus_resp), 32'(me.resp));
            if (me.chk_rd) check(bus_rdata === me.rdata, me.req, "read data", bus_rdata, me.rdata);
          end
        end
      end
      if (bus_sel && bus_trans[1] && bus_ready) begin
        in_dp = 1; lows = 0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(0, "ALL", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_wait[i] = 0; m_resp[i] = 0; m_lim[i] = 0; m_used[i] = 0;
    end
    rst_n = 0; bus_sel = 0; bus_trans = 0; bus_addr = 0; bus_write = 0; bus_size = 0;
    bus_wdata = 0; cfg_we = 0; cfg_idx = 0; cfg_wait = 0; cfg_resp = 0; cfg_limit = 0;
    seq_clear = 0;
    repeat (3) @(posedge clk);
    #1;
    check(bus_ready == 1 && bus_resp == 0, "R1", "outputs in reset", {bus_ready, bus_resp}, 3'b100);
    rst_n = 1;
    @(posedge clk); #1;
    check(bus_ready == 1 && bus_resp == 0, "R1", "outputs after reset", {bus_ready, bus_resp}, 3'b100);

    // R1 defaults and R8 byte lanes
    xfer(0, 2, 1, 32'h11223344, 0, "R1");
    xfer(4, 2, 1, 32'hA5A5A5A5, 0, "R1");
    xfer(8, 2, 1, 32'hCAFEF00D, 0, "R8");
    xfer(12, 2, 1, 32'h01020304, 0, "R8");
    xfer(5, 0, 1, 32'h0000EE00, 0, "R8");
    xfer(6, 1, 1, 32'hBEEF0000, 0, "R8");
    xfer(4, 2, 0, 0, 0, "R8");
    xfer(0, 2, 0, 0, 0, "R8");
    xfer(13, 1, 1, 32'h00007788, 0, "R8");
    xfer(12, 2, 0, 0, 0, "R8");

    // R2 stall lengths
    clear_seq();
    cfg(0, 3, 0, 0);
    cfg(1, 1, 0, 0);
    cfg(2, 7, 0, 0);
    xfer(0, 2, 0, 0, 0, "R2");
    xfer(12, 2, 1, 32'h5566AABB, 0, "R2");
    xfer(12, 2, 0, 0, 0, "R2");
    xfer(4, 2, 0, 0, 0, "R2");

    // R3 forced codes and R9 memory untouched
    clear_seq();
    cfg(0, 2, 1, 0);
    cfg(1, 0, 2, 0);
    cfg(2, 0, 0, 0);
    xfer(8, 2, 1, 32'hDEADDEAD, 0, "R9");
    xfer(8, 0, 1, 32'h000000FF, 0, "R3");
    xfer(8, 2, 0, 0, 0, "R9");

    // R4 usage limit and restart on reprogram
    cfg(0, 0, 2, 2);
    for (int n = 0; n < 3; n++) xfer(0, 2, 0, 0, 1, "R4");
    cfg(0, 0, 2, 2);
    xfer(0, 2, 0, 0, 1, "R4");
    xfer(0, 2, 0, 0, 1, "R4");
    xfer(0, 2, 0, 0, 1, "R4");

    // R5 unlimited
    cfg(0, 1, 1, 0);
    for (int n = 0; n < 5; n++) xfer(0, 2, 0, 0, 1, "R5");

    // R6 code 3 stored as OKAY
    cfg(0, 0, 3, 0);
    xfer(0, 2, 0, 0, 1, "R6");
    xfer(0, 2, 0, 0, 1, "R6");

    // R7 wrap modulo 16
    clear_seq();
    cfg(0, 2, 0, 0);
    cfg(1, 0, 0, 0);
    cfg(15, 1, 0, 0);
    for (int n = 0; n < 18; n++) xfer(0, 2, 0, 0, 0, "R7");

    // R7 clear coincident with accept
    cfg(0, 0, 1, 0);
    cfg(1, 2, 0, 0);
    clear_seq();
    xfer(0, 2, 0, 0, 0, "R7");
    xfer(0, 2, 0, 0, 0, "R7");
    xfer(0, 2, 0, 0, 0, "R7");
    xfer(4, 2, 0, 0, 1, "R7");
    xfer(4, 2, 0, 0, 0, "R7");

    // R10 non-transfers do not count
    cfg(m_idx, 2, 0, 0);
    bus_sel = 1; bus_trans = 2'b00;
    @(posedge clk); #1;
    check(bus_ready == 1 && bus_resp == 0, "R10", "idle outputs", {bus_ready, bus_resp}, 3'b100);
    bus_sel = 1; bus_trans = 2'b01;
    @(posedge clk); #1;
    bus_sel = 0; bus_trans = 2'b10;
    @(posedge clk); #1;
    check(bus_ready == 1 && bus_resp == 0, "R10", "unselected outputs", {bus_ready, bus_resp}, 3'b100);
    bus_trans = 2'b00;
    xfer(0, 2, 0, 0, 0, "R10");

    repeat (3) @(posedge clk);
    check(q.size() == 0, "R10", "pending scoreboard items", 32'(q.size()), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule